// File: doc/BRIEF.md
# UART Script Engine

This block plays back a short script of operations held in a byte image that is fixed when the design is elaborated. It feeds a UART transmitter one byte at a time and listens to a UART receiver. A program counter walks the image. Each operation code is followed by its operands: a timed pause, a zero-terminated text string to send, a byte to wait for, or a jump target. A stop code, or any code the engine does not know, parks the engine until reset.

Everything runs on the single system clock. A divider inside the block produces a one-cycle enable at sixteen times the baud rate, for the serial transmitter and receiver that sit beside the block. Those serial engines are not part of this block. The transmitter reports back through a buffer-full input, and the receiver hands over a byte with a valid strobe.

Top module: `uart_script_engine`

## Requirements
- R1: While reset is high and in the first cycle after it, tx_wr and baud_tick16 are low. Execution starts at image address 0.
- R2: baud_tick16 is high for one cycle every DIV clocks, where DIV = CLK_HZ/(16*BAUD) (at least 1). It is first high in cycle DIV after reset release and in every multiple of DIV after that.
- R3: Opcode 0xF1 followed by a count byte n pauses for n*UNIT_CLKS+1 cycles. A script that starts with 0xF1 n and then a message puts its first tx_wr in cycle n*UNIT_CLKS+5 after reset release.
- R4: Opcode 0xF2 is followed by text bytes that end with 0x00. Each non-zero byte goes out on tx_data with a tx_wr pulse, in image order. The 0x00 is not sent.
- R5: tx_wr lasts exactly one cycle and is never high in two consecutive cycles. It is never high in the cycle after a clock edge at which tx_full was high.
- R6: Opcode 0xF3 followed by byte b stalls until a cycle with rx_valid high and rx_data equal to b. Any other received byte has no effect, and no byte is sent during the stall.
- R7: Opcode 0xF4 followed by address a continues execution at address a.
- R8: A pause count of 0 adds no wait. A script that starts with 0xF1 0x00 and then a message puts its first tx_wr in cycle 4.
- R9: Opcode 0xF0 stops the engine, and no further tx_wr occurs while reset stays low. A reset restarts the script from address 0 with the same timing as after the first reset.
- R10: Any byte in opcode position other than 0xF1 to 0xF4 acts as 0xF0. Addresses beyond the image read as 0xF0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | output | 8 | Byte offered to the transmitter |
| tx_wr | output | 1 | One-cycle write strobe for tx_data |
| tx_full | input | 1 | Transmitter buffer cannot take a byte |
| rx_data | input | 8 | Byte delivered by the receiver |
| rx_valid | input | 1 | rx_data is valid this cycle |
| baud_tick16 | output | 1 | Enable pulse at sixteen times the baud rate |

## Verification
The bench sweeps every one of the 255 wrong bytes into a pending wait. A comparator that matches on the wrong width or value, or that latches the first received byte, would start sending early. It measures the exact cycle of the first write after a non-zero pause and after a zero pause. An off-by-one in the unit counter, or a zero count treated as 256, moves that cycle. It holds the transmitter busy after every byte, which catches an engine that uses a stale full flag and overruns the buffer. It also runs separate scripts that end in a stop code and in an unknown code, and it restarts the engine with a reset in the middle of a run. An engine that ran past either code, or failed to rewind, would send extra text or misplace its first write.

// File: rtl/use_pkg.sv
package use_pkg;
  localparam int BYTE_W = 8;
  localparam int PC_W   = 8;

  localparam logic [7:0] OP_STOP  = 8'hF0;
  localparam logic [7:0] OP_PAUSE = 8'hF1;
  localparam logic [7:0] OP_TEXT  = 8'hF2;
  localparam logic [7:0] OP_AWAIT = 8'hF3;
  localparam logic [7:0] OP_JUMP  = 8'hF4;
  localparam logic [7:0] TEXT_END = 8'h00;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_PAUSE_ARG,
    ST_PAUSE_RUN,
    ST_TEXT,
    ST_TEXT_GAP,
    ST_AWAIT,
    ST_JUMP,
    ST_STOP
  } eng_state_t;
endpackage

// File: rtl/use_tick_gen.sv
module use_tick_gen #(
  parameter int CLK_HZ = 100_000_000,
  parameter int BAUD   = 115_200
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int DIV_RAW = CLK_HZ / (16 * BAUD);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int CW      = (DIV < 2) ? 1 : $clog2(DIV);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == CW'(DIV - 1));
      if (cnt == CW'(DIV - 1)) cnt <= '0;
      else                     cnt <= cnt + 1'b1;
    end
  end

  generate
    if (DIV > 1) begin : g_spacing
      assert_tick_single_R2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/use_prog_rom.sv
module use_prog_rom #(
  parameter int AW  = 8,
  parameter int LEN = 16,
  parameter logic [8*LEN-1:0] IMAGE = '0
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [7:0]    q
);
  import use_pkg::*;
  localparam int DEPTH = 1 << AW;

  logic [7:0] rom_w [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      if (i < LEN) begin : g_used
        assign rom_w[i] = IMAGE[8*i +: 8];
      end else begin : g_pad
        assign rom_w[i] = OP_STOP;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    q <= rom_w[addr];
  end
endmodule

// File: rtl/use_delay_timer.sv
module use_delay_timer #(
  parameter int UNIT_CLKS = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] count,
  output logic       expired
);
  localparam int UNIT = (UNIT_CLKS < 1) ? 1 : UNIT_CLKS;
  localparam int SW   = (UNIT < 2) ? 1 : $clog2(UNIT);

  logic [7:0]    units;
  logic [SW-1:0] sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      units <= '0;
      sub   <= '0;
    end else if (load) begin
      units <= count;
      sub   <= SW'(UNIT - 1);
    end else if (units != 8'd0) begin
      if (sub == '0) begin
        sub   <= SW'(UNIT - 1);
        units <= units - 1'b1;
      end else begin
        sub <= sub - 1'b1;
      end
    end
  end

  assign expired = (units == 8'd0);

  assert_timer_steps_down_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && units != 8'd0) |=> (units == $past(units) || units == $past(units) - 8'd1));
endmodule

// File: rtl/uart_script_engine.sv
module uart_script_engine #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int BAUD      = 115_200,
  parameter int UNIT_CLKS = 100_000,
  parameter int PROG_LEN  = 16,
  parameter logic [8*PROG_LEN-1:0] PROG_IMAGE = {
    8'h02, 8'hF4, 8'h00, 8'h6B, 8'h6F, 8'hF2, 8'h41, 8'hF3,
    8'h00, 8'h0A, 8'h0D, 8'h69, 8'h48, 8'hF2, 8'hC8, 8'hF1}
) (
  input  logic       clk,
  input  logic       rst,
  output logic [7:0] tx_data,
  output logic       tx_wr,
  input  logic       tx_full,
  input  logic [7:0] rx_data,
  input  logic       rx_valid,
  output logic       baud_tick16
);
  import use_pkg::*;

  eng_state_t       st_q, st_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [7:0]       rom_q;
  logic [7:0]       data_d;
  logic             wr_d;
  logic             tmr_load;
  logic             tmr_expired;

  use_tick_gen #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_tick (
    .clk(clk), .rst(rst), .tick(baud_tick16));

  use_prog_rom #(.AW(PC_W), .LEN(PROG_LEN), .IMAGE(PROG_IMAGE)) u_rom (
    .clk(clk), .addr(pc_d), .q(rom_q));

  use_delay_timer #(.UNIT_CLKS(UNIT_CLKS)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .count(rom_q), .expired(tmr_expired));

  always_comb begin
    st_d     = st_q;
    pc_d     = pc_q;
    wr_d     = 1'b0;
    data_d   = tx_data;
    tmr_load = 1'b0;
    case (st_q)
      ST_FETCH: begin
        case (rom_q)
          OP_PAUSE: begin pc_d = pc_q + 1'b1; st_d = ST_PAUSE_ARG; end
          OP_TEXT:  begin pc_d = pc_q + 1'b1; st_d = ST_TEXT;      end
          OP_AWAIT: begin pc_d = pc_q + 1'b1; st_d = ST_AWAIT;     end
          OP_JUMP:  begin pc_d = pc_q + 1'b1; st_d = ST_JUMP;      end
          default:  st_d = ST_STOP;
        endcase
      end
      ST_PAUSE_ARG: begin
        tmr_load = 1'b1;
        pc_d     = pc_q + 1'b1;
        st_d     = (rom_q == 8'd0) ? ST_FETCH : ST_PAUSE_RUN;
      end
      ST_PAUSE_RUN: begin
        if (tmr_expired) st_d = ST_FETCH;
      end
      ST_TEXT: begin
        if (rom_q == TEXT_END) begin
          pc_d = pc_q + 1'b1;
          st_d = ST_FETCH;
        end else if (!tx_full) begin
          wr_d   = 1'b1;
          data_d = rom_q;
          pc_d   = pc_q + 1'b1;
          st_d   = ST_TEXT_GAP;
        end
      end
      ST_TEXT_GAP: st_d = ST_TEXT;
      ST_AWAIT: begin
        if (rx_valid && rx_data == rom_q) begin
          pc_d = pc_q + 1'b1;
          st_d = ST_FETCH;
        end
      end
      ST_JUMP: begin
        pc_d = rom_q;
        st_d = ST_FETCH;
      end
      default: st_d = ST_STOP;
    endcase
    if (rst) pc_d = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_FETCH;
      pc_q    <= '0;
      tx_wr   <= 1'b0;
      tx_data <= 8'h00;
    end else begin
      st_q    <= st_d;
      pc_q    <= pc_d;
      tx_wr   <= wr_d;
      tx_data <= data_d;
    end
  end

  assert_strobe_gap_R5: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> !tx_wr);

  assert_no_write_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    tx_full |=> !tx_wr);

  assert_await_holds_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_AWAIT && !(rx_valid && rx_data == rom_q)) |=>
      (st_q == ST_AWAIT && $stable(pc_q) && !tx_wr));

  assert_stop_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STOP) |=> (st_q == ST_STOP && $stable(pc_q) && !tx_wr));
endmodule

// File: tb/sim_uart_script_engine.sv
module sim_uart_script_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  localparam int UNIT = 3;

  logic [7:0] d0, d1, d2, rxd;
  logic       w0, w1, w2, full0, rxv, tk0, tk1, tk2;

  uart_script_engine #(.CLK_HZ(1_600_000), .BAUD(20_000), .UNIT_CLKS(UNIT), .PROG_LEN(16),
    .PROG_IMAGE({8'h02, 8'hF4, 8'h00, 8'h6B, 8'h6F, 8'hF2, 8'h41, 8'hF3,
                 8'h00, 8'h0A, 8'h0D, 8'h69, 8'h48, 8'hF2, 8'h02, 8'hF1})) u0 (
    .clk(clk), .rst(rst), .tx_data(d0), .tx_wr(w0), .tx_full(full0),
    .rx_data(rxd), .rx_valid(rxv), .baud_tick16(tk0));

  uart_script_engine #(.CLK_HZ(1_600_000), .BAUD(20_000), .UNIT_CLKS(UNIT), .PROG_LEN(9),
    .PROG_IMAGE({8'h00, 8'h79, 8'hF2, 8'hF0, 8'h00, 8'h78, 8'hF2, 8'h00, 8'hF1})) u1 (
    .clk(clk), .rst(rst), .tx_data(d1), .tx_wr(w1), .tx_full(1'b0),
    .rx_data(rxd), .rx_valid(rxv), .baud_tick16(tk1));

  uart_script_engine #(.CLK_HZ(1_600_000), .BAUD(20_000), .UNIT_CLKS(UNIT), .PROG_LEN(7),
    .PROG_IMAGE({8'h00, 8'h77, 8'hF2, 8'h5A, 8'h00, 8'h7A, 8'hF2})) u2 (
    .clk(clk), .rst(rst), .tx_data(d2), .tx_wr(w2), .tx_full(1'b0),
    .rx_data(rxd), .rx_valid(rxv), .baud_tick16(tk2));

  int total = 0;
  int bad = 0;
  logic [7:0] log0 [64];
  logic [7:0] log1 [64];
  logic [7:0] log2 [64];
  int n0 = 0, n1 = 0, n2 = 0;
  int busy_cnt = 0;
  int overrun = 0;
  int back2back = 0;
  logic prev_w0 = 1'b0;
  int cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // transmitter model and byte logger, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (w0 && full0) overrun++;
      if (w0 && prev_w0) back2back++;
      if (w0 && n0 < 64) begin log0[n0] = d0; n0++; end
      if (w1 && n1 < 64) begin log1[n1] = d1; n1++; end
      if (w2 && n2 < 64) begin log2[n2] = d2; n2++; end
      prev_w0 = w0;
      if (w0) busy_cnt = 4;
      else if (busy_cnt > 0) busy_cnt--;
      full0 = (busy_cnt != 0);
    end else begin
      busy_cnt = 0;
      full0 = 1'b0;
      prev_w0 = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_from_reset(output int f0, output int f1, output int f2, output int tick_err);
    f0 = -1; f1 = -1; f2 = -1; tick_err = 0;
    @(negedge clk);
    rst = 1'b0;
    n0 = 0; n1 = 0; n2 = 0;
    for (int k = 1; k <= 40; k++) begin
      @(posedge clk);
      #1;
      if (w0 && f0 < 0) f0 = k;
      if (w1 && f1 < 0) f1 = k;
      if (w2 && f2 < 0) f2 = k;
      if (tk0 != ((k % 5) == 0)) tick_err++;
    end
  endtask

  initial begin
    int f0, f1, f2, te;
    logic [7:0] exp_seq [10];
    exp_seq = '{8'h48, 8'h69, 8'h0D, 8'h0A, 8'h6F, 8'h6B, 8'h48, 8'h69, 8'h0D, 8'h0A};
    rxd = 8'h00; rxv = 1'b0; full0 = 1'b0;
    wait_cycles(4);
    // R1: quiet during reset
    chk(!w0 && !w1 && !w2, "R1", "tx_wr during reset", int'(w0 | w1 | w2), 0);
    chk(!tk0, "R1", "baud_tick16 during reset", int'(tk0), 0);

    run_from_reset(f0, f1, f2, te);
    chk(te == 0, "R2", "tick pattern mismatches over 40 cycles", te, 0);
    chk(f0 == 2 * UNIT + 5, "R3", "first write cycle after pause 2", f0, 2 * UNIT + 5);
    chk(f1 == 4, "R8", "first write cycle after pause 0", f1, 4);
    chk(f2 == 2, "R1", "script starts at address 0", f2, 2);

    wait_cycles(60);
    chk(n0 == 4, "R4", "bytes of first message", n0, 4);
    for (int i = 0; i < 4; i++)
      chk(log0[i] == exp_seq[i], "R4", $sformatf("message byte %0d", i), log0[i], exp_seq[i]);

    // R6: every wrong byte is ignored while waiting
    for (int b = 0; b < 256; b++) begin
      if (b != 8'h41) begin
        rxd = 8'(b); rxv = 1'b1;
        @(negedge clk);
        rxv = 1'b0;
        @(negedge clk);
      end
    end
    wait_cycles(20);
    chk(n0 == 4, "R6", "bytes sent during wrong-byte sweep", n0, 4);

    rxd = 8'h41; rxv = 1'b1;
    @(negedge clk);
    rxv = 1'b0;
    wait_cycles(200);
    chk(n0 == 10, "R6", "bytes after matching byte", n0, 10);
    for (int i = 4; i < 6; i++)
      chk(log0[i] == exp_seq[i], "R6", $sformatf("reply byte %0d", i), log0[i], exp_seq[i]);
    for (int i = 6; i < 10; i++)
      chk(log0[i] == exp_seq[i], "R7", $sformatf("byte %0d after jump", i), log0[i], exp_seq[i]);

    chk(overrun == 0, "R5", "writes while buffer full", overrun, 0);
    chk(back2back == 0, "R5", "back-to-back strobes", back2back, 0);

    chk(n1 == 1, "R9", "bytes sent by stopped script", n1, 1);
    chk(log1[0] == 8'h78, "R9", "byte before stop", log1[0], 8'h78);
    chk(n2 == 1, "R10", "bytes sent before unknown code", n2, 1);
    chk(log2[0] == 8'h7A, "R10", "byte before unknown code", log2[0], 8'h7A);

    // R9: reset in mid-run restarts from address 0
    @(negedge clk);
    rst = 1'b1;
    wait_cycles(3);
    run_from_reset(f0, f1, f2, te);
    chk(f0 == 2 * UNIT + 5, "R9", "first write cycle after restart", f0, 2 * UNIT + 5);
    chk(n0 >= 1 && log0[0] == 8'h48, "R9", "first byte after restart", log0[0], 8'h48);
    chk(te == 0, "R2", "tick pattern after restart", te, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule